// File: doc/BRIEF.md
# PCI Configuration Command Register with Error Gating

This block stores the 16-bit command word of a PCI function's configuration header and drives the logic that its enable bits control. A host writes the word through a simple configuration strobe and reads it back combinationally. Bits that the function does not implement read as zero, and writes to them are dropped. The implemented bits go out one by one as enable outputs.

The same bits gate the parity error reporting. An address parity error can raise a system error request only when both the system error enable and the parity response enable are set. A data parity error raises a parity error request only when parity response is enabled, and it pulses the master data parity status flag only when the error occurred during a master cycle. Every detected parity error pulses the detected parity status flag, whatever the enables hold.

The bits also gate memory decode, pick the command code used for write bursts (memory write and invalidate or plain memory write), and allow fast back-to-back cycles. The hard reset clears the register. The soft reset and the stop control leave it as it is.

Top module: `pci_cmd_reg_ctl`

## Requirements
- R1: Only bits 9, 8, 6, 4, 2 and 1 are writable (mask 16'h0356). All other bits, including bit 0, read zero and ignore writes.
- R2: Each writable bit drives its own enable output: bit 9 fast back-to-back, bit 8 system error, bit 6 parity response, bit 4 invalidate writes, bit 2 bus master, bit 1 memory space.
- R3: A write sampled at a rising clock edge is visible on the read port right after that edge and not before it; the read port is combinational from the stored value.
- R4: Asserting the active-low hard reset clears every writable bit at once.
- R5: The soft reset and the stop control do not change the stored value.
- R6: `serr_req` is high exactly when an address parity error is present and bits 8 and 6 are both 1.
- R7: With bit 6 at 0, a parity error of either kind produces only the `dpe_pulse` output; `serr_req`, `perr_req` and `dataperr_pulse` stay low.
- R8: With bit 6 at 1, a data parity error raises `perr_req`. `dataperr_pulse` is raised only when `err_master` is also high.
- R9: `mem_hit` equals `mem_match` while bit 1 is 1 and is forced low while it is 0.
- R10: `wr_cmd` is 4'hF (memory write and invalidate) while bit 4 is 1 and 4'h7 (memory write) while it is 0.
- R11: `b2b_go` follows `b2b_req` only while bit 9 is 1.
- R12: `dpe_pulse` is high in every cycle in which either parity error input is high, whatever the enables hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_hard_n | input | 1 | Hard reset, active low, asserted asynchronously |
| soft_rst | input | 1 | Soft reset; has no effect on the register |
| stop_set | input | 1 | Stop control; has no effect on the register |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read data |
| err_addr_par | input | 1 | Address parity error detected this cycle |
| err_data_par | input | 1 | Data parity error detected this cycle |
| err_master | input | 1 | The data parity error occurred in a master cycle |
| mem_match | input | 1 | Raw memory address decode match |
| b2b_req | input | 1 | Request for a fast back-to-back cycle |
| en_fbtb | output | 1 | Fast back-to-back enable |
| en_serr | output | 1 | System error enable |
| en_perr | output | 1 | Parity response enable |
| en_mwi | output | 1 | Invalidate-write enable |
| en_bm | output | 1 | Bus master enable |
| en_mem | output | 1 | Memory space enable |
| serr_req | output | 1 | System error assertion request |
| perr_req | output | 1 | Parity error assertion request |
| dpe_pulse | output | 1 | Detected parity status pulse |
| dataperr_pulse | output | 1 | Master data parity status pulse |
| mem_hit | output | 1 | Gated memory decode hit |
| wr_cmd | output | 4 | Command code for write bursts |
| b2b_go | output | 1 | Fast back-to-back permitted |

## Verification
The case hardest to reach from the ports is the full set of error gating outcomes. Each outcome depends on the stored state of two enable bits together with the error kind and the master flag presented in the same cycle. The stimulus table writes each of the four enable combinations and then applies address errors, data errors in master and target cycles, and both error kinds at once. Directed steps then check that a write becomes visible only after its edge, that the soft reset and the stop control leave a stored value alone, and that the hard reset clears the register without waiting for the clock.

// File: rtl/pcmd_pkg.sv
package pcmd_pkg;
  localparam int CMD_W   = 16;
  localparam int CODE_W  = 4;
  localparam int B_FBTB  = 9;
  localparam int B_SERR  = 8;
  localparam int B_PERR  = 6;
  localparam int B_MWI   = 4;
  localparam int B_BM    = 2;
  localparam int B_MEM   = 1;
  localparam logic [CMD_W-1:0] WMASK =
    (CMD_W'(1) << B_FBTB) | (CMD_W'(1) << B_SERR) | (CMD_W'(1) << B_PERR) |
    (CMD_W'(1) << B_MWI)  | (CMD_W'(1) << B_BM)   | (CMD_W'(1) << B_MEM);
  localparam logic [CODE_W-1:0] CODE_MWI = 4'hF;
  localparam logic [CODE_W-1:0] CODE_MW  = 4'h7;
endpackage

// File: rtl/pcmd_rst_sync.sv
module pcmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pcmd_store.sv
module pcmd_store
  import pcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CMD_W-1:0] wdata,
  input  logic             soft_rst,
  input  logic             stop_set,
  output logic [CMD_W-1:0] cmd_q
);
  logic [CMD_W-1:0] cmd_d;
  logic             cmd_en;

  assign cmd_en = wr;

  always_comb begin
    cmd_d = cmd_q;
    if (cmd_en) cmd_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  assert_wr_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cmd_q == ($past(wdata) & WMASK));

  assert_soft_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((soft_rst || stop_set) && !wr) |=> $stable(cmd_q));

  assert_resv_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cmd_q & ~WMASK) == '0);
endmodule

// File: rtl/pcmd_err_gate.sv
module pcmd_err_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic serr_en,
  input  logic perr_en,
  input  logic addr_err,
  input  logic data_err,
  input  logic master_cyc,
  output logic serr_req,
  output logic perr_req,
  output logic dpe_pulse,
  output logic dataperr_pulse
);
  logic respond;

  always_comb begin
    respond        = perr_en;
    dpe_pulse      = addr_err | data_err;
    serr_req       = addr_err & serr_en & respond;
    perr_req       = data_err & respond;
    dataperr_pulse = data_err & respond & master_cyc;
  end

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_en |-> !serr_req && !perr_req && !dataperr_pulse);

  assert_dataperr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dataperr_pulse |-> perr_req && master_cyc);

  assert_serr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |-> dpe_pulse && serr_en && perr_en);

  assert_dpe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (serr_req || perr_req) |-> dpe_pulse);
endmodule

// File: rtl/pcmd_gates.sv
module pcmd_gates
  import pcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_en,
  input  logic              mwi_en,
  input  logic              fbtb_en,
  input  logic              mem_match,
  input  logic              b2b_req,
  output logic              mem_hit,
  output logic [CODE_W-1:0] wr_cmd,
  output logic              b2b_go
);
  always_comb begin
    mem_hit = mem_match & mem_en;
    wr_cmd  = mwi_en ? CODE_MWI : CODE_MW;
    b2b_go  = b2b_req & fbtb_en;
  end

  assert_hit_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_hit |-> mem_en && mem_match);

  assert_b2b_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    b2b_go |-> fbtb_en);

  assert_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd == CODE_MWI) || (wr_cmd == CODE_MW));
endmodule

// File: rtl/pci_cmd_reg_ctl.sv
module pci_cmd_reg_ctl
  import pcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_hard_n,
  input  logic              soft_rst,
  input  logic              stop_set,
  input  logic              cfg_wr,
  input  logic [CMD_W-1:0]  cfg_wdata,
  output logic [CMD_W-1:0]  cfg_rdata,
  input  logic              err_addr_par,
  input  logic              err_data_par,
  input  logic              err_master,
  input  logic              mem_match,
  input  logic              b2b_req,
  output logic              en_fbtb,
  output logic              en_serr,
  output logic              en_perr,
  output logic              en_mwi,
  output logic              en_bm,
  output logic              en_mem,
  output logic              serr_req,
  output logic              perr_req,
  output logic              dpe_pulse,
  output logic              dataperr_pulse,
  output logic              mem_hit,
  output logic [CODE_W-1:0] wr_cmd,
  output logic              b2b_go
);
  logic             rst_n;
  logic [CMD_W-1:0] cmd_q;

  pcmd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_hard_n), .rst_n(rst_n)
  );

  pcmd_store u_store (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
    .soft_rst(soft_rst), .stop_set(stop_set), .cmd_q(cmd_q)
  );

  assign cfg_rdata = cmd_q & WMASK;
  assign en_fbtb   = cmd_q[B_FBTB];
  assign en_serr   = cmd_q[B_SERR];
  assign en_perr   = cmd_q[B_PERR];
  assign en_mwi    = cmd_q[B_MWI];
  assign en_bm     = cmd_q[B_BM];
  assign en_mem    = cmd_q[B_MEM];

  pcmd_err_gate u_err (
    .clk(clk), .rst_n(rst_n), .serr_en(en_serr), .perr_en(en_perr),
    .addr_err(err_addr_par), .data_err(err_data_par), .master_cyc(err_master),
    .serr_req(serr_req), .perr_req(perr_req), .dpe_pulse(dpe_pulse),
    .dataperr_pulse(dataperr_pulse)
  );

  pcmd_gates u_gates (
    .clk(clk), .rst_n(rst_n), .mem_en(en_mem), .mwi_en(en_mwi),
    .fbtb_en(en_fbtb), .mem_match(mem_match), .b2b_req(b2b_req),
    .mem_hit(mem_hit), .wr_cmd(wr_cmd), .b2b_go(b2b_go)
  );

  assert_hard_clear_R4: assert property (@(posedge clk)
    !rst_n |-> cfg_rdata == '0);
endmodule

// File: tb/pci_cmd_reg_ctl_test.sv
module pci_cmd_reg_ctl_test;
  logic        clk = 1'b0;
  logic        rst_hard_n, soft_rst, stop_set, cfg_wr;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        err_addr_par, err_data_par, err_master, mem_match, b2b_req;
  logic        en_fbtb, en_serr, en_perr, en_mwi, en_bm, en_mem;
  logic        serr_req, perr_req, dpe_pulse, dataperr_pulse, mem_hit, b2b_go;
  logic [3:0]  wr_cmd;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  pci_cmd_reg_ctl uut (
    .clk(clk), .rst_hard_n(rst_hard_n), .soft_rst(soft_rst), .stop_set(stop_set),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .err_addr_par(err_addr_par), .err_data_par(err_data_par), .err_master(err_master),
    .mem_match(mem_match), .b2b_req(b2b_req),
    .en_fbtb(en_fbtb), .en_serr(en_serr), .en_perr(en_perr), .en_mwi(en_mwi),
    .en_bm(en_bm), .en_mem(en_mem), .serr_req(serr_req), .perr_req(perr_req),
    .dpe_pulse(dpe_pulse), .dataperr_pulse(dataperr_pulse), .mem_hit(mem_hit),
    .wr_cmd(wr_cmd), .b2b_go(b2b_go)
  );

  // stimulus: wdata[16], addr_par, data_par, master, mem_match, b2b_req
  // expected: rdata[16], serr, perr, dpe, dataperr, hit, cmd[4], b2b
  localparam int NV = 16;
  localparam logic [46:0] TBL [NV] = '{
    {16'hFFFF, 5'b00011, 16'h0356, 5'b00001, 4'hF, 1'b1}, // R1 R9 R10 R11
    {16'h0000, 5'b10011, 16'h0000, 5'b00100, 4'h7, 1'b0}, // R7 R12
    {16'h0000, 5'b01100, 16'h0000, 5'b00100, 4'h7, 1'b0}, // R7
    {16'h0100, 5'b10000, 16'h0100, 5'b00100, 4'h7, 1'b0}, // R6 serr only
    {16'h0100, 5'b01100, 16'h0100, 5'b00100, 4'h7, 1'b0}, // R7
    {16'h0040, 5'b10000, 16'h0040, 5'b00100, 4'h7, 1'b0}, // R6 perr only
    {16'h0040, 5'b01100, 16'h0040, 5'b01110, 4'h7, 1'b0}, // R8 master
    {16'h0040, 5'b01000, 16'h0040, 5'b01100, 4'h7, 1'b0}, // R8 target
    {16'h0140, 5'b10000, 16'h0140, 5'b10100, 4'h7, 1'b0}, // R6 both
    {16'h0140, 5'b01100, 16'h0140, 5'b01110, 4'h7, 1'b0}, // R8
    {16'h0140, 5'b11000, 16'h0140, 5'b11100, 4'h7, 1'b0}, // R6 R8
    {16'h0002, 5'b00010, 16'h0002, 5'b00001, 4'h7, 1'b0}, // R9
    {16'h0010, 5'b00010, 16'h0010, 5'b00000, 4'hF, 1'b0}, // R9 R10
    {16'h0200, 5'b00001, 16'h0200, 5'b00000, 4'h7, 1'b1}, // R11
    {16'hFCA9, 5'b00011, 16'h0000, 5'b00000, 4'h7, 1'b0}, // R1 reserved only
    {16'h0004, 5'b00000, 16'h0004, 5'b00000, 4'h7, 1'b0}  // R2 bus master
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_hard_n = 1'b0; soft_rst = 1'b0; stop_set = 1'b0; cfg_wr = 1'b0;
    cfg_wdata = '0; err_addr_par = 1'b0; err_data_par = 1'b0; err_master = 1'b0;
    mem_match = 1'b0; b2b_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_hard_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check("R4 reset value", cfg_rdata, 16'h0000);
    check("R10 reset cmd", {12'h0, wr_cmd}, 16'h0007);

    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      v = TBL[i];
      cfg_write(v[46:31]);
      {err_addr_par, err_data_par, err_master, mem_match, b2b_req} = v[30:26];
      #2;
      check($sformatf("R1/R3 vec%0d rdata", i), cfg_rdata, v[25:10]);
      check($sformatf("R6-R9 R12 vec%0d flags", i),
            {11'h0, serr_req, perr_req, dpe_pulse, dataperr_pulse, mem_hit}, {11'h0, v[9:5]});
      check($sformatf("R10 R11 vec%0d cmd/b2b", i), {11'h0, wr_cmd, b2b_go}, {11'h0, v[4:0]});
      @(negedge clk);
      {err_addr_par, err_data_par, err_master, mem_match, b2b_req} = 5'b0;
    end

    // R2: enables mirror their bits
    cfg_write(16'h0356);
    #2;
    check("R2 all enables", {10'h0, en_fbtb, en_serr, en_perr, en_mwi, en_bm, en_mem}, 16'h003F);
    cfg_write(16'h0004);
    #2;
    check("R2 bus master only", {10'h0, en_fbtb, en_serr, en_perr, en_mwi, en_bm, en_mem}, 16'h0002);

    // R3: not visible before the capturing edge
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 16'h0140;
    #2;
    check("R3 before edge", cfg_rdata, 16'h0004);
    @(posedge clk); #2;
    check("R3 after edge", cfg_rdata, 16'h0140);
    @(negedge clk); cfg_wr = 1'b0;

    // R5: soft reset and stop keep the value
    @(negedge clk); soft_rst = 1'b1; stop_set = 1'b1;
    @(negedge clk); @(negedge clk); soft_rst = 1'b0;
    @(negedge clk); stop_set = 1'b0;
    #2;
    check("R5 hold after soft/stop", cfg_rdata, 16'h0140);

    // R4: hard reset clears without a clock edge
    cfg_write(16'h0356);
    #3; rst_hard_n = 1'b0; #2;
    check("R4 async clear", cfg_rdata, 16'h0000);
    repeat (2) @(negedge clk);
    rst_hard_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check("R4 after release", cfg_rdata, 16'h0000);

    finish_run();
  end
endmodule